// File: doc/BRIEF.md
# Non-Speculative Branch Issue Gate

This block sits beside the issue stage of an out-of-order core that has no speculation. Each conditional branch is predicted not taken. Issue may run past an unresolved conditional branch. Every instruction issued in its shadow is marked, and a marked instruction may not start execution. The block records the reservation slot of each marked instruction. It releases those slots when the branch resolves not taken, and it flushes them and redirects fetch when the branch resolves taken.

Unconditional jumps (jump-and-link through a register, and return) have no predicted path. While one is unresolved, all issue is held until its target comes back, and then fetch is redirected. Only one branch of either kind may be outstanding at a time. The block also keeps four saturating event counters: completed instructions, conditional branches, elapsed cycles and mispredictions.

Top module: `branch_gate`

## Requirements
- R1: After reset, `iss_stall`, `flush_vld`, `flush_mask`, `redir_vld` and all four counters are zero, and every bit of `exec_ok` is one.
- R2: `iss_kind` uses this encoding: 0 or 3 is an ordinary instruction, 1 is a conditional branch and 2 is a jump. An issue is accepted when `iss_vld` is high and `iss_stall` is low. While a conditional branch is pending, `iss_stall` is high in any cycle where `iss_kind` is 1 or 2, and low for an ordinary instruction.
- R3: While a jump is pending, `iss_stall` is high whatever the value of `iss_kind`.
- R4: An ordinary instruction accepted while a conditional branch is pending, with `iss_slot` below NSLOT, clears `exec_ok[iss_slot]` from the following cycle onward.
- R5: When a pending conditional branch resolves not taken (`res_vld` high, `res_taken` low), no flush and no redirect follow. The cleared `exec_ok` bits return to one in the next cycle.
- R6: When a pending conditional branch resolves taken, `flush_vld` and `redir_vld` pulse for one cycle in the next cycle. `redir_pc` equals `res_target`. `flush_mask` holds every shadowed slot, including a slot accepted in the resolving cycle. `flush_mask` is zero whenever `flush_vld` is low.
- R7: When a pending jump resolves, `redir_vld` pulses with `redir_pc` equal to `res_target`, whatever `res_taken` is. There is no flush, and no misprediction is counted.
- R8: `res_vld` has no effect when no branch is pending.
- R9: `cnt_done` counts cycles with `cmt_vld` high, `cnt_branch` counts accepted conditional branches, `cnt_mispred` counts taken resolutions of conditional branches, and `cnt_cycle` counts every clock out of reset.
- R10: Every counter stops at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | An instruction is offered for issue |
| iss_kind | input | 2 | Instruction class (0/3 ordinary, 1 conditional, 2 jump) |
| iss_slot | input | SLOT_W | Reservation slot the instruction goes to |
| res_vld | input | 1 | Branch unit reports a resolution |
| res_taken | input | 1 | Conditional branch outcome |
| res_target | input | PC_W | Resolved target address |
| cmt_vld | input | 1 | One instruction completed its write stage |
| iss_stall | output | 1 | Offered instruction is not accepted this cycle |
| exec_ok | output | NSLOT | Per-slot permission to begin execution |
| flush_vld | output | 1 | Squash the slots in `flush_mask` |
| flush_mask | output | NSLOT | Slots issued on the wrong path |
| redir_vld | output | 1 | Redirect fetch |
| redir_pc | output | PC_W | Redirect address |
| cnt_done | output | CNT_W | Completed instructions |
| cnt_branch | output | CNT_W | Conditional branches encountered |
| cnt_cycle | output | CNT_W | Cycles elapsed |
| cnt_mispred | output | CNT_W | Mispredicted branches |

## Verification
The bench targets several corner cases and what a faulty design would show in each:
- An ordinary instruction issued in the same cycle a taken branch resolves must be in the flush mask. Without it, a wrong-path instruction would run.
- A resolution reported with nothing pending must change nothing. A faulty design would redirect fetch or clear the pending state at random.
- A jump resolution with `res_taken` low must still redirect. It must not be counted as a misprediction.
- The counters run with a narrow width so that they reach saturation. A design that wrapped would show small counts again after the all-ones value.

// File: rtl/bg_pkg.sv
package bg_pkg;
   typedef enum logic [1:0] {
      K_ORD  = 2'd0,
      K_COND = 2'd1,
      K_JUMP = 2'd2,
      K_RSV  = 2'd3
   } kind_e;
endpackage

// File: rtl/bg_counter.sv
module bg_counter #(
   parameter int W   = 32,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_w
         $error("bg_counter: W must be at least 2");
      end
      if (SAT) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                q <= '0;
            else if (inc && q != TOP)  q <= q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (inc) q <= q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/bg_shadow.sv
module bg_shadow #(
   parameter int NSLOT = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSLOT-1:0] set_vec,
   input  logic             clr_all,
   output logic [NSLOT-1:0] shadow
);
   always_ff @(posedge clk) begin
      if (!rst_n)       shadow <= '0;
      else if (clr_all) shadow <= '0;
      else              shadow <= shadow | set_vec;
   end
endmodule

// File: rtl/bg_redirect.sv
module bg_redirect #(
   parameter int NSLOT = 9,
   parameter int PC_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_flush,
   input  logic             do_redir,
   input  logic [NSLOT-1:0] squash_vec,
   input  logic [PC_W-1:0]  target,
   output logic             flush_vld,
   output logic [NSLOT-1:0] flush_mask,
   output logic             redir_vld,
   output logic [PC_W-1:0]  redir_pc
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_vld  <= 1'b0;
         flush_mask <= '0;
         redir_vld  <= 1'b0;
         redir_pc   <= '0;
      end else begin
         flush_vld  <= do_flush;
         flush_mask <= do_flush ? squash_vec : '0;
         redir_vld  <= do_redir;
         if (do_redir) redir_pc <= target;
      end
   end
endmodule

// File: rtl/branch_gate.sv
module branch_gate
   import bg_pkg::*;
#(
   parameter int NSLOT  = 9,
   parameter int PC_W   = 16,
   parameter int CNT_W  = 32,
   parameter bit SAT    = 1'b1,
   localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_vld,
   input  logic [1:0]        iss_kind,
   input  logic [SLOT_W-1:0] iss_slot,
   input  logic              res_vld,
   input  logic              res_taken,
   input  logic [PC_W-1:0]   res_target,
   input  logic              cmt_vld,
   output logic              iss_stall,
   output logic [NSLOT-1:0]  exec_ok,
   output logic              flush_vld,
   output logic [NSLOT-1:0]  flush_mask,
   output logic              redir_vld,
   output logic [PC_W-1:0]   redir_pc,
   output logic [CNT_W-1:0]  cnt_done,
   output logic [CNT_W-1:0]  cnt_branch,
   output logic [CNT_W-1:0]  cnt_cycle,
   output logic [CNT_W-1:0]  cnt_mispred
);
   generate
      if (NSLOT < 2) begin : g_bad_nslot
         $error("branch_gate: NSLOT must be at least 2");
      end
      if (PC_W < 2) begin : g_bad_pcw
         $error("branch_gate: PC_W must be at least 2");
      end
   endgenerate

   kind_e            kind;
   logic             pend, pend_jump;
   logic             is_br, acc, acc_cond, acc_jump, acc_ord;
   logic             res_ok, do_flush, do_redir, slot_ok;
   logic [NSLOT-1:0] set_vec, shadow, squash_vec;

   assign kind      = kind_e'(iss_kind);
   assign is_br     = (kind == K_COND) || (kind == K_JUMP);
   assign iss_stall = pend && (pend_jump || is_br);
   assign acc       = iss_vld && !iss_stall;
   assign acc_cond  = acc && (kind == K_COND);
   assign acc_jump  = acc && (kind == K_JUMP);
   assign acc_ord   = acc && !is_br;
   assign slot_ok   = (int'(iss_slot) < NSLOT);
   assign set_vec   = (acc_ord && pend && !pend_jump && slot_ok)
                      ? (NSLOT'(1) << iss_slot) : '0;
   assign res_ok    = res_vld && pend;
   assign do_flush  = res_ok && !pend_jump && res_taken;
   assign do_redir  = res_ok && (pend_jump || res_taken);
   assign squash_vec = shadow | set_vec;
   assign exec_ok   = ~shadow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_jump <= 1'b0;
      end else if (res_ok) begin
         pend      <= 1'b0;
         pend_jump <= 1'b0;
      end else if (acc_cond || acc_jump) begin
         pend      <= 1'b1;
         pend_jump <= acc_jump;
      end
   end

   bg_shadow #(.NSLOT(NSLOT)) u_shadow (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
      .clr_all(res_ok), .shadow(shadow)
   );

   bg_redirect #(.NSLOT(NSLOT), .PC_W(PC_W)) u_redir (
      .clk(clk), .rst_n(rst_n), .do_flush(do_flush), .do_redir(do_redir),
      .squash_vec(squash_vec), .target(res_target),
      .flush_vld(flush_vld), .flush_mask(flush_mask),
      .redir_vld(redir_vld), .redir_pc(redir_pc)
   );

   logic [3:0]       cnt_inc;
   logic [CNT_W-1:0] cnt_q [4];
   assign cnt_inc = {do_flush, 1'b1, acc_cond, cmt_vld};

   generate
      for (genvar g = 0; g < 4; g++) begin : g_cnt
         bg_counter #(.W(CNT_W), .SAT(SAT)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(cnt_inc[g]), .q(cnt_q[g])
         );
      end
   endgenerate

   assign cnt_done    = cnt_q[0];
   assign cnt_branch  = cnt_q[1];
   assign cnt_cycle   = cnt_q[2];
   assign cnt_mispred = cnt_q[3];
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
   parameter int NSLOT = 9,
   parameter int CNT_W = 32,
   localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iss_vld,
   input logic [1:0]        iss_kind,
   input logic              iss_stall,
   input logic [NSLOT-1:0]  exec_ok,
   input logic              flush_vld,
   input logic [NSLOT-1:0]  flush_mask,
   input logic              redir_vld,
   input logic [CNT_W-1:0]  cnt_cycle,
   input logic [CNT_W-1:0]  cnt_branch,
   input logic [CNT_W-1:0]  cnt_mispred
);
   AST_COND_BLOCKS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld && iss_kind == 2'd1 && !iss_stall) |=>
      (iss_kind == 2'd0 || iss_kind == 2'd3 || iss_stall)); // R2
   AST_JUMP_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld && iss_kind == 2'd2 && !iss_stall) |=> iss_stall); // R3
   AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |=> !flush_vld); // R6
   AST_FLUSH_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |-> redir_vld); // R6
   AST_FLUSH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |-> (&exec_ok)); // R6
   AST_MASK_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_vld |-> (flush_mask == '0)); // R6
   AST_MISPRED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_mispred <= cnt_branch); // R9
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cnt_cycle >= $past(cnt_cycle))); // R10
endmodule

bind branch_gate bg_checker #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_kind(iss_kind),
   .iss_stall(iss_stall), .exec_ok(exec_ok), .flush_vld(flush_vld),
   .flush_mask(flush_mask), .redir_vld(redir_vld), .cnt_cycle(cnt_cycle),
   .cnt_branch(cnt_branch), .cnt_mispred(cnt_mispred)
);

// File: tb/branch_gate_tb.sv
`timescale 1ns/1ps
module branch_gate_tb;
   localparam int NSLOT = 9;
   localparam int PC_W  = 16;
   localparam int CNT_W = 8;
   localparam int SLOT_W = $clog2(NSLOT);
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iss_vld = 1'b0, res_vld = 1'b0, res_taken = 1'b0, cmt_vld = 1'b0;
   logic [1:0] iss_kind = '0;
   logic [SLOT_W-1:0] iss_slot = '0;
   logic [PC_W-1:0] res_target = '0;
   logic iss_stall, flush_vld, redir_vld;
   logic [NSLOT-1:0] exec_ok, flush_mask;
   logic [PC_W-1:0] redir_pc;
   logic [CNT_W-1:0] cnt_done, cnt_branch, cnt_cycle, cnt_mispred;

   always #4 clk = ~clk;

   branch_gate #(.NSLOT(NSLOT), .PC_W(PC_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_kind(iss_kind),
      .iss_slot(iss_slot), .res_vld(res_vld), .res_taken(res_taken),
      .res_target(res_target), .cmt_vld(cmt_vld), .iss_stall(iss_stall),
      .exec_ok(exec_ok), .flush_vld(flush_vld), .flush_mask(flush_mask),
      .redir_vld(redir_vld), .redir_pc(redir_pc), .cnt_done(cnt_done),
      .cnt_branch(cnt_branch), .cnt_cycle(cnt_cycle), .cnt_mispred(cnt_mispred)
   );

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   // reference state
   bit m_pend = 0, m_jump = 0, m_flush = 0, m_redir = 0;
   bit m_shadow [NSLOT];
   bit m_fmask  [NSLOT];
   int m_pc = 0;
   int m_done = 0, m_br = 0, m_cyc = 0, m_mis = 0;

   task automatic chk(string req, string what, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int sat_inc(int v);
      return (v < CMAX) ? v + 1 : v;
   endfunction

   function automatic bit m_stall();
      return m_pend && (m_jump || iss_kind == 2'd1 || iss_kind == 2'd2);
   endfunction

   task automatic model_step();
      bit acc, br, res_ok, newset [NSLOT];
      acc = iss_vld && !m_stall();
      br  = (iss_kind == 2'd1) || (iss_kind == 2'd2);
      foreach (newset[i]) newset[i] = 0;
      if (acc && !br && m_pend && !m_jump && int'(iss_slot) < NSLOT) newset[iss_slot] = 1;
      res_ok = res_vld && m_pend;
      m_flush = res_ok && !m_jump && res_taken;
      m_redir = res_ok && (m_jump || res_taken);
      if (m_redir) m_pc = int'(res_target);
      foreach (m_fmask[i]) m_fmask[i] = m_flush && (m_shadow[i] || newset[i]);
      if (cmt_vld) m_done = sat_inc(m_done);
      if (acc && iss_kind == 2'd1) m_br = sat_inc(m_br);
      if (m_flush) m_mis = sat_inc(m_mis);
      m_cyc = sat_inc(m_cyc);
      if (res_ok) begin
         m_pend = 0; m_jump = 0;
         foreach (m_shadow[i]) m_shadow[i] = 0;
      end else begin
         if (acc && br) begin m_pend = 1; m_jump = (iss_kind == 2'd2); end
         foreach (m_shadow[i]) m_shadow[i] = m_shadow[i] || newset[i];
      end
   endtask

   task automatic compare_all();
      chk("R2 R3", "iss_stall", iss_stall, m_stall());
      for (int i = 0; i < NSLOT; i++) begin
         chk("R4 R5", "exec_ok bit", exec_ok[i], !m_shadow[i]);
         chk("R6", "flush_mask bit", flush_mask[i], m_fmask[i]);
      end
      chk("R6 R8", "flush_vld", flush_vld, m_flush);
      chk("R6 R7 R8", "redir_vld", redir_vld, m_redir);
      if (m_redir) chk("R6 R7", "redir_pc", redir_pc, m_pc);
      chk("R9 R10", "cnt_done", cnt_done, m_done);
      chk("R9 R10", "cnt_branch", cnt_branch, m_br);
      chk("R9 R10", "cnt_cycle", cnt_cycle, m_cyc);
      chk("R7 R9", "cnt_mispred", cnt_mispred, m_mis);
   endtask

   task automatic drive_random();
      int r;
      iss_vld  = ($urandom % 3) != 0;
      r = $urandom % 8;
      iss_kind = (r < 5) ? 2'd0 : (r == 5) ? 2'd1 : (r == 6) ? 2'd2 : 2'd3;
      iss_slot = SLOT_W'($urandom % NSLOT);
      res_vld  = m_pend ? (($urandom % 3) == 0) : (($urandom % 6) == 0); // R8 when idle
      res_taken = $urandom % 2;
      res_target = PC_W'($urandom);
      cmt_vld  = ($urandom % 4) == 0;
   endtask

   initial begin
      foreach (m_shadow[i]) begin m_shadow[i] = 0; m_fmask[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", "iss_stall", iss_stall, 0);
      chk("R1", "exec_ok", exec_ok, {NSLOT{1'b1}});
      chk("R1", "flush_vld", flush_vld, 0);
      chk("R1", "flush_mask", flush_mask, 0);
      chk("R1", "redir_vld", redir_vld, 0);
      chk("R1", "cnt_cycle", cnt_cycle, 0);
      chk("R1", "cnt_done", cnt_done, 0);
      rst_n = 1'b1;
      drive_random();
      for (int c = 0; c < 4000; c++) begin
         @(posedge clk);
         model_step();
         @(negedge clk);
         compare_all();
         drive_random();
      end
      chk("R10", "cnt_cycle saturated", cnt_cycle, CMAX);
      chk("R10", "cnt_done saturated", cnt_done, CMAX);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule